// File: doc/BRIEF.md
# USB IN Endpoint Request Controller

This block runs the device side of one USB IN endpoint. It sits between a simplified token and handshake interface from the serial engine and the CPU register interface. When the host sends an IN token, the controller looks at the endpoint buffer. If the CPU has committed a packet, it asks the serial engine to send data. If not, it asks for a NAK, and once that handshake has gone out it raises a transfer-request flag. The CPU services the flag in three steps: it clears the flag, loads the transmit bytes, and strobes packet-enable.

A committed packet stays in the buffer until the host ACKs it. A timeout with no ACK leaves the packet in place so it can be sent again. The request flag is set once for every NAK, so a second IN token that comes before the commit raises the flag again. The CPU must expect these repeated requests. The same controller can serve the IN direction of a control endpoint or of a bulk or interrupt endpoint.

The CPU clears the buffer with a clear command. That command has no effect while DMA is enabled for the endpoint.

Top module: `usb_in_ep_ctrl`

## Requirements
- R1: If an IN token arrives while the controller is idle and no packet is committed, `send_nak_o` pulses for one cycle on the next clock edge and `send_data_o` stays low.
- R2: A NAK does not set the request flag when the token arrives. `flag_o` goes high on the clock edge that samples `hs_done_i` while the controller is waiting for the NAK handshake to finish.
- R3: Every IN token that arrives before packet-enable is answered with another NAK, and sets the flag again after that handshake, even if the CPU has already cleared the flag.
- R4: If an IN token arrives while a packet is committed, `send_data_o` pulses one cycle later. At the same time `data_len_o` shows the number of bytes written and `rd_data_o` shows the first byte. Each `rd_en_i` moves to the next byte in write order. `send_nak_o` and `send_data_o` are never high together.
- R5: When the host ACKs a sent packet, the packet is released, `data_len_o` returns to 0, and the next IN token is answered with a NAK.
- R6: When `ack_timeout_i` arrives instead of an ACK, the packet stays committed, and the next IN token sends it again with the same length.
- R7: Writing 1 on `flag_clr_i` clears the flag. If a NAK completes in the same cycle as a clear, the flag ends up set.
- R8: `irq_o` is a register loaded with `flag_o AND irq_en_i`, so it follows them one cycle later.
- R9: A byte write made after packet-enable and before the release is discarded and does not change `data_len_o`. It sets `wr_err_o`, which stays high until `err_clr_i` is pulsed.
- R10: `buf_clr_i` is ignored while `dma_en_i` is high, and the committed packet and its length are kept. With DMA disabled, the clear empties the buffer.
- R11: A packet-enable with no bytes written commits a zero-length packet. The next IN token sends it as data with `data_len_o` = 0.
- R12: Byte writes beyond MAX_BYTES are dropped, and `data_len_o` stays at MAX_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| in_token_i | input | 1 | Pulse: an IN token was received for this endpoint |
| hs_done_i | input | 1 | Pulse: the NAK handshake has been sent |
| host_ack_i | input | 1 | Pulse: the host ACKed the data packet |
| ack_timeout_i | input | 1 | Pulse: no ACK arrived in time |
| send_nak_o | output | 1 | Pulse: request a NAK handshake |
| send_data_o | output | 1 | Pulse: request a data packet |
| data_len_o | output | LEN_W | Number of bytes in the buffer |
| rd_en_i | input | 1 | Serial engine moves to the next byte |
| rd_data_o | output | DATA_W | Current transmit byte |
| wr_byte_i | input | 1 | CPU writes one transmit byte |
| wr_data_i | input | DATA_W | Byte to write |
| pkt_en_i | input | 1 | CPU packet-enable (commit) strobe |
| flag_clr_i | input | 1 | Write-one-to-clear for the request flag |
| irq_en_i | input | 1 | Interrupt enable |
| err_clr_i | input | 1 | Clears the write-error status |
| buf_clr_i | input | 1 | Buffer-clear command |
| dma_en_i | input | 1 | DMA enabled for this endpoint |
| flag_o | output | 1 | Transfer-request flag |
| irq_o | output | 1 | Registered interrupt request |
| wr_err_o | output | 1 | A byte write was blocked |

## Verification
Every stimulus is held for exactly one clock edge and the outputs are sampled on the following falling edge. Tokens, the NAK handshake done pulse, ACK, commit and writes therefore show their results at that sample: `send_nak_o`, `send_data_o`, `flag_o`, `data_len_o` and `wr_err_o` are each one register stage away from their cause. `irq_o` adds one more register, so it is checked one cycle after the flag. The bench checks the flag both at the token sample and at the handshake-done sample, which shows that the flag is set at handshake completion and not at the token.

// File: rtl/usb_in_ep_pkg.sv
package usb_in_ep_pkg;
  typedef enum logic [1:0] {
    EP_IDLE     = 2'd0,
    EP_NAK_WAIT = 2'd1,
    EP_DATA_WAIT = 2'd2
  } ep_state_e;
endpackage

// File: rtl/usb_in_ep_buf.sv
module usb_in_ep_buf #(
  parameter int MAX_BYTES = 64,
  parameter int DATA_W    = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1),
  localparam int PTR_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              release_i,
  input  logic              clr_i,
  input  logic              dma_en_i,
  input  logic              err_clr_i,
  input  logic              start_i,
  input  logic              rd_i,
  output logic              committed_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              wr_err_o
);
  logic [DATA_W-1:0] mem_q [MAX_BYTES];
  logic [LEN_W-1:0]  count_q;
  logic [PTR_W-1:0]  rd_ptr_q;
  logic              committed_q, err_q;
  logic              full, clr_ok, wr_ok;

  assign full   = (count_q == LEN_W'(MAX_BYTES));
  assign clr_ok = clr_i && !dma_en_i;
  assign wr_ok  = wr_i && !committed_q && !full;

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[count_q[PTR_W-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q     <= '0;
      committed_q <= 1'b0;
    end else if (release_i || clr_ok) begin
      count_q     <= '0;
      committed_q <= 1'b0;
    end else begin
      if (wr_ok)    count_q     <= count_q + 1'b1;
      if (commit_i) committed_q <= 1'b1;
    end
  end

  // blocked write: buffer committed and not yet released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        err_q <= 1'b0;
    else if (wr_i && committed_q)       err_q <= 1'b1;
    else if (err_clr_i)                 err_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_ptr_q <= '0;
    else if (start_i) rd_ptr_q <= '0;
    else if (rd_i)    rd_ptr_q <= rd_ptr_q + 1'b1;
  end

  assign committed_o = committed_q;
  assign len_o       = count_q;
  assign rd_data_o   = mem_q[rd_ptr_q];
  assign wr_err_o    = err_q;

  AST_WR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && committed_q && !release_i && !clr_ok) |=> ($stable(count_q) && err_q)); // R9

  AST_CLR_IGNORED_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && dma_en_i && !release_i && committed_q) |=> $stable(committed_q)); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= LEN_W'(MAX_BYTES)); // R12
endmodule

// File: rtl/usb_in_ep_fsm.sv
module usb_in_ep_fsm
  import usb_in_ep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_token_i,
  input  logic hs_done_i,
  input  logic host_ack_i,
  input  logic ack_timeout_i,
  input  logic committed_i,
  output logic send_nak_o,
  output logic send_data_o,
  output logic start_o,
  output logic nak_done_o,
  output logic release_o
);
  ep_state_e state_q;
  logic      nak_q, data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EP_IDLE;
      nak_q   <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      nak_q  <= 1'b0;
      data_q <= 1'b0;
      unique case (state_q)
        EP_IDLE: if (in_token_i) begin
          if (committed_i) begin
            data_q  <= 1'b1;
            state_q <= EP_DATA_WAIT;
          end else begin
            nak_q   <= 1'b1;
            state_q <= EP_NAK_WAIT;
          end
        end
        EP_NAK_WAIT:  if (hs_done_i) state_q <= EP_IDLE;
        EP_DATA_WAIT: if (host_ack_i || ack_timeout_i) state_q <= EP_IDLE;
        default: state_q <= EP_IDLE;
      endcase
    end
  end

  assign send_nak_o  = nak_q;
  assign send_data_o = data_q;
  assign start_o     = (state_q == EP_IDLE) && in_token_i && committed_i;
  assign nak_done_o  = (state_q == EP_NAK_WAIT) && hs_done_i;
  assign release_o   = (state_q == EP_DATA_WAIT) && host_ack_i;

  AST_NAK_WHEN_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == EP_IDLE && in_token_i && !committed_i) |=> (send_nak_o && !send_data_o)); // R1

  AST_ONE_REPLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(send_nak_o && send_data_o)); // R4

  AST_TIMEOUT_NO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == EP_DATA_WAIT && ack_timeout_i && !host_ack_i) |-> !release_o); // R6
endmodule

// File: rtl/usb_in_ep_irq.sv
module usb_in_ep_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  // set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= flag_q && en_i;
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  AST_FLAG_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(set_i)); // R2

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> flag_q); // R7

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(flag_q && en_i)); // R8
endmodule

// File: rtl/usb_in_ep_ctrl.sv
module usb_in_ep_ctrl #(
  parameter int MAX_BYTES = 64,
  parameter int DATA_W    = 8,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_token_i,
  input  logic              hs_done_i,
  input  logic              host_ack_i,
  input  logic              ack_timeout_i,
  output logic              send_nak_o,
  output logic              send_data_o,
  output logic [LEN_W-1:0]  data_len_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_byte_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pkt_en_i,
  input  logic              flag_clr_i,
  input  logic              irq_en_i,
  input  logic              err_clr_i,
  input  logic              buf_clr_i,
  input  logic              dma_en_i,
  output logic              flag_o,
  output logic              irq_o,
  output logic              wr_err_o
);
  logic committed, start, nak_done, release_pkt;

  usb_in_ep_fsm u_fsm (
    .clk_i, .rst_ni, .in_token_i, .hs_done_i, .host_ack_i, .ack_timeout_i,
    .committed_i (committed),
    .send_nak_o, .send_data_o,
    .start_o     (start),
    .nak_done_o  (nak_done),
    .release_o   (release_pkt)
  );

  usb_in_ep_buf #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_i        (wr_byte_i),
    .wr_data_i,
    .commit_i    (pkt_en_i),
    .release_i   (release_pkt),
    .clr_i       (buf_clr_i),
    .dma_en_i,
    .err_clr_i,
    .start_i     (start),
    .rd_i        (rd_en_i),
    .committed_o (committed),
    .len_o       (data_len_o),
    .rd_data_o,
    .wr_err_o
  );

  usb_in_ep_irq u_irq (
    .clk_i, .rst_ni,
    .set_i  (nak_done),
    .clr_i  (flag_clr_i),
    .en_i   (irq_en_i),
    .flag_o,
    .irq_o
  );

  AST_PKT_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_pkt |=> (data_len_o == '0)); // R5
endmodule

// File: tb/usb_in_ep_ctrl_tb.sv
module usb_in_ep_ctrl_tb;
  localparam int MAXB = 64;
  localparam int LW = $clog2(MAXB + 1);

  logic clk = 0, rst_n = 0;
  logic tok = 0, hs = 0, ack = 0, tmo = 0, rd = 0, wr = 0, pen = 0;
  logic fclr = 0, ien = 0, eclr = 0, bclr = 0, dma = 0;
  logic [7:0] wd = 0;
  logic nak, dat, flag, irq, werr;
  logic [LW-1:0] len;
  logic [7:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  usb_in_ep_ctrl #(.MAX_BYTES(MAXB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .in_token_i(tok), .hs_done_i(hs),
    .host_ack_i(ack), .ack_timeout_i(tmo), .send_nak_o(nak), .send_data_o(dat),
    .data_len_o(len), .rd_en_i(rd), .rd_data_o(rdata), .wr_byte_i(wr),
    .wr_data_i(wd), .pkt_en_i(pen), .flag_clr_i(fclr), .irq_en_i(ien),
    .err_clr_i(eclr), .buf_clr_i(bclr), .dma_en_i(dma), .flag_o(flag),
    .irq_o(irq), .wr_err_o(werr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // each stimulus pulse spans one rising edge; caller samples after return
  task automatic p_tok();  tok = 1;  @(negedge clk); tok = 0;  endtask
  task automatic p_hs();   hs = 1;   @(negedge clk); hs = 0;   endtask
  task automatic p_ack();  ack = 1;  @(negedge clk); ack = 0;  endtask
  task automatic p_tmo();  tmo = 1;  @(negedge clk); tmo = 0;  endtask
  task automatic p_pen();  pen = 1;  @(negedge clk); pen = 0;  endtask
  task automatic p_fclr(); fclr = 1; @(negedge clk); fclr = 0; endtask
  task automatic p_rd();   rd = 1;   @(negedge clk); rd = 0;   endtask
  task automatic p_wr(input logic [7:0] b); wr = 1; wd = b; @(negedge clk); wr = 0; endtask
  task automatic p_bclr(); bclr = 1; @(negedge clk); bclr = 0; endtask

  task automatic t_reset();
    eq("R1 reset nak", nak, 0);
    eq("R4 reset data", dat, 0);
    eq("R2 reset flag", flag, 0);
    eq("R8 reset irq", irq, 0);
    eq("R9 reset err", werr, 0);
    eq("R5 reset len", len, 0);
  endtask

  task automatic t_nak_flag();
    p_tok();
    eq("R1 nak pulse", nak, 1);
    eq("R1 no data", dat, 0);
    eq("R2 flag not at token", flag, 0);
    @(negedge clk);
    eq("R1 nak one cycle", nak, 0);
    eq("R2 flag still low before hs", flag, 0);
    p_hs();
    eq("R2 flag after hs", flag, 1);
  endtask

  task automatic t_repeat();
    p_fclr();
    eq("R7 w1c clears", flag, 0);
    p_tok();
    eq("R3 second nak", nak, 1);
    eq("R3 flag low at token", flag, 0);
    p_hs();
    eq("R3 flag set again", flag, 1);
    p_fclr();
  endtask

  task automatic t_set_wins();
    p_tok();
    hs = 1; fclr = 1; @(negedge clk); hs = 0; fclr = 0;
    eq("R7 set wins", flag, 1);
    p_fclr();
    eq("R7 cleared", flag, 0);
  endtask

  task automatic t_irq();
    ien = 1;
    p_tok(); p_hs();
    eq("R8 irq lags flag", irq, 0);
    @(negedge clk);
    eq("R8 irq high", irq, 1);
    ien = 0; @(negedge clk);
    eq("R8 irq masked", irq, 0);
    p_fclr();
  endtask

  task automatic t_data_ack();
    p_wr(8'hA1); p_wr(8'hB2); p_wr(8'hC3);
    eq("R4 len before commit", len, 3);
    p_pen();
    p_wr(8'h55);
    eq("R9 err set", werr, 1);
    eq("R9 len unchanged", len, 3);
    p_tok();
    eq("R4 data pulse", dat, 1);
    eq("R4 no nak", nak, 0);
    eq("R4 len", len, 3);
    eq("R4 byte0", rdata, 8'hA1);
    p_rd(); eq("R4 byte1", rdata, 8'hB2);
    p_rd(); eq("R4 byte2", rdata, 8'hC3);
    p_ack();
    eq("R5 released len", len, 0);
    eq("R9 err sticky", werr, 1);
    eclr = 1; @(negedge clk); eclr = 0;
    eq("R9 err cleared", werr, 0);
    p_tok();
    eq("R5 nak after ack", nak, 1);
    p_hs(); p_fclr();
  endtask

  task automatic t_timeout();
    p_wr(8'h11); p_wr(8'h22); p_pen();
    p_tok();
    eq("R6 first send", dat, 1);
    p_tmo();
    eq("R6 kept len", len, 2);
    p_tok();
    eq("R6 resend", dat, 1);
    eq("R6 resend len", len, 2);
    eq("R6 resend byte0", rdata, 8'h11);
    p_ack();
  endtask

  task automatic t_clr_dma();
    p_wr(8'h77); p_wr(8'h88); p_pen();
    dma = 1; p_bclr();
    eq("R10 ignored under dma", len, 2);
    p_tok();
    eq("R10 still committed", dat, 1);
    p_tmo();
    dma = 0; p_bclr();
    eq("R10 cleared", len, 0);
    p_tok();
    eq("R10 nak after clear", nak, 1);
    p_hs(); p_fclr();
  endtask

  task automatic t_zlp();
    p_pen();
    p_tok();
    eq("R11 zlp sent as data", dat, 1);
    eq("R11 zlp nak low", nak, 0);
    eq("R11 zlp len", len, 0);
    p_ack();
  endtask

  task automatic t_full();
    for (int i = 0; i < MAXB + 3; i++) p_wr(8'(i));
    eq("R12 capped len", len, MAXB);
    p_bclr();
    eq("R12 cleared", len, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_nak_flag();
    t_repeat();
    t_set_wins();
    t_irq();
    t_data_ack();
    t_timeout();
    t_clr_dma();
    t_zlp();
    t_full();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule